// File: doc/BRIEF.md
# External Interrupt Sense Unit

The unit watches four asynchronous interrupt input pins and turns activity on them into interrupt requests. Each pin is configured on its own through a 2-bit sense field. The field selects one of four conditions: a low level, any edge, a falling edge or a rising edge. Edge conditions are stored in a per-pin flag. The flag stays set until the interrupt-acknowledge logic pulses that pin's clear strobe. The low-level condition is never stored: its request follows the synchronized pin for as long as the pin is held low.

Every pin passes through a two-flop synchronizer. Edges are then found by comparing the synchronized value with its value one cycle earlier. Edge recognition depends on the I/O clock. While the clock-run input is low, no edge sets a flag, and an edge that occurs during that time is not reported afterwards. Level sensing keeps working while the clock-run input is low. The per-pin enable only gates the request. Flags keep recording edges while the enable is low, so a request appears as soon as the enable is raised. A pin that the device drives itself is sensed in the same way as an external one, so toggling it raises an interrupt from software.

Top module: `extint_sense`

## Requirements
- R1: During and after reset, with every pin held high, flag_o and req_o are all zero. The synchronizer and edge-history registers reset to the high level, so releasing reset causes no edge.
- R2: The sense field of pin n is mode_i[2n+1:2n]. A pin change made before a clock edge sets the flag after the third rising edge. After the second rising edge the flag is still clear.
- R3: With sense code 10 (falling edge), a high-to-low change sets the flag and a low-to-high change does not.
- R4: With sense code 11 (rising edge), a low-to-high change sets the flag and a high-to-low change does not.
- R5: With sense code 01 (any edge), both directions set the flag.
- R6: With sense code 00 (low level), req_o of the pin is high exactly while the synchronized pin is low: it rises after the second rising edge after the pin falls and drops after the second rising edge after the pin rises. The request is not latched, and flag_o of the pin stays zero.
- R7: While clk_run_i is low, no flag is set. An edge that occurred in that window is not reported once clk_run_i returns high.
- R8: A clr_i bit sampled high at a rising edge clears that pin's flag at that edge.
- R9: When an edge is detected in the same cycle as the clear strobe of that pin, the flag ends up set.
- R10: With en_i low, a pin's req_o stays zero, but its edge flag is still set. In edge modes req_o equals the flag ANDed with the enable, with no added delay.
- R11: While a pin's sense code is 00, its flag is cleared at each rising edge, so a flag latched earlier in an edge mode is lost.
- R12: Pins are independent. Each pin follows only its own sense code, enable and clear bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | Raw interrupt pins, asynchronous |
| en_i | input | 4 | Per-pin request enable |
| mode_i | input | 8 | Sense codes, 2 bits per pin: 00 low, 01 any edge, 10 falling, 11 rising |
| clk_run_i | input | 1 | High while the I/O clock runs; gates edge recognition |
| clr_i | input | 4 | Per-pin flag clear strobe from interrupt acknowledge |
| flag_o | output | 4 | Latched edge flags |
| req_o | output | 4 | Interrupt requests |

## Verification
The assertions assume that only pin_i is asynchronous. They also assume that mode_i, en_i, clr_i and clk_run_i are synchronous to clk_i and stable around the rising edge. This lets a flag drop be traced to a clear or a level-mode cycle one cycle earlier, and a flag rise to a running clock and an edge-mode code one cycle earlier. The bench drives every input, the pins included, on the falling clock edge, and it keeps the pins high across every reset. Under these conditions the cycle counts in R2 and R6 are exact and reset cannot produce a false edge.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_mode_e;

  localparam int unsigned SENSE_W = 2;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_LVL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= {(STAGES*WIDTH){RST_LVL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/extint_edge.sv
module extint_edge #(
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic run_i,
  output logic rise_o,
  output logic fall_o
);

  logic prev_q;

  // history tracks even while halted so no stale edge appears on resume
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_LVL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = run_i &  lvl_i & ~prev_q;
  assign fall_o = run_i & ~lvl_i &  prev_q;

endmodule

// File: rtl/extint_chan.sv
module extint_chan
  import extint_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  sense_mode_e mode_i,
  input  logic        en_i,
  input  logic        lvl_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        clr_i,
  output logic        flag_o,
  output logic        req_o
);

  logic flag_q;
  logic hit;
  logic level_mode;

  assign level_mode = (mode_i == SENSE_LOW);

  always_comb begin
    unique case (mode_i)
      SENSE_LOW:  hit = 1'b0;
      SENSE_ANY:  hit = rise_i | fall_i;
      SENSE_FALL: hit = fall_i;
      SENSE_RISE: hit = rise_i;
    endcase
  end

  // new edge beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (level_mode) flag_q <= 1'b0;
    else if (hit)        flag_q <= 1'b1;
    else if (clr_i)      flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign req_o  = en_i & (level_mode ? ~lvl_i : flag_q);

endmodule

// File: rtl/extint_sense.sv
module extint_sense
  import extint_pkg::*;
#(
  parameter int unsigned N_PINS      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        IDLE_LVL    = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_PINS-1:0]         pin_i,
  input  logic [N_PINS-1:0]         en_i,
  input  logic [N_PINS*SENSE_W-1:0] mode_i,
  input  logic                      clk_run_i,
  input  logic [N_PINS-1:0]         clr_i,
  output logic [N_PINS-1:0]         flag_o,
  output logic [N_PINS-1:0]         req_o
);

  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] rise;
  logic [N_PINS-1:0] fall;

  extint_sync #(
    .WIDTH   (N_PINS),
    .STAGES  (SYNC_STAGES),
    .RST_LVL (IDLE_LVL)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    extint_edge #(
      .RST_LVL (IDLE_LVL)
    ) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (pin_sync[g]),
      .run_i  (clk_run_i),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );

    extint_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (sense_mode_e'(mode_i[g*SENSE_W +: SENSE_W])),
      .en_i   (en_i[g]),
      .lvl_i  (pin_sync[g]),
      .rise_i (rise[g]),
      .fall_i (fall[g]),
      .clr_i  (clr_i[g]),
      .flag_o (flag_o[g]),
      .req_o  (req_o[g])
    );
  end

endmodule

// File: rtl/extint_sense_chk.sv
module extint_sense_chk #(
  parameter int unsigned N_PINS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_PINS-1:0]   en_i,
  input logic [N_PINS*2-1:0] mode_i,
  input logic                clk_run_i,
  input logic [N_PINS-1:0]   clr_i,
  input logic [N_PINS-1:0]   flag_o,
  input logic [N_PINS-1:0]   req_o
);

  for (genvar g = 0; g < N_PINS; g++) begin : g_chk
    // R10
    a_r10_req_gated_by_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[g] |-> !req_o[g]);

    // R11
    a_r11_level_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[2*g +: 2] == 2'b00) |=> !flag_o[g]);

    // R7
    a_r7_no_set_when_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[g]) |-> $past(clk_run_i));

    // R8
    a_r8_drop_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_o[g]) |-> ($past(clr_i[g]) || ($past(mode_i[2*g +: 2]) == 2'b00)));

    // R6
    a_r6_level_flag_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[g]) |-> ($past(mode_i[2*g +: 2]) != 2'b00));
  end

endmodule

bind extint_sense extint_sense_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .mode_i    (mode_i),
  .clk_run_i (clk_run_i),
  .clr_i     (clr_i),
  .flag_o    (flag_o),
  .req_o     (req_o)
);

// File: tb/sim_extint_sense.sv
`timescale 1ns/1ps
module sim_extint_sense;

  localparam int N = 4;
  localparam logic [1:0] M_LOW  = 2'b00;
  localparam logic [1:0] M_ANY  = 2'b01;
  localparam logic [1:0] M_FALL = 2'b10;
  localparam logic [1:0] M_RISE = 2'b11;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   pin = '1;
  logic [N-1:0]   en = '1;
  logic [2*N-1:0] mode = {N{M_FALL}};
  logic           run = 1'b1;
  logic [N-1:0]   clr = '0;
  logic [N-1:0]   flag;
  logic [N-1:0]   req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  extint_sense u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pin_i     (pin),
    .en_i      (en),
    .mode_i    (mode),
    .clk_run_i (run),
    .clr_i     (clr),
    .flag_o    (flag),
    .req_o     (req)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2*N-1:0] m);
    @(negedge clk);
    rst_n = 1'b0; pin = '1; en = '1; run = 1'b1; clr = '0; mode = m;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse_clr(input logic [N-1:0] c);
    clr = c;
    tick(1);
    clr = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0; pin = '1; mode = {N{M_ANY}};
    #1;
    chk("R1", "flag in reset", flag, '0);
    chk("R1", "req in reset", req, '0);
    tick(2);
    rst_n = 1'b1;
    tick(5);
    chk("R1", "flag after release", flag, '0);
    chk("R1", "req after release", req, '0);
  endtask

  task automatic t_fall(input int p);
    do_reset({N{M_FALL}});
    pin[p] = 1'b0;
    tick(2);
    chk("R2", "flag before latency", flag, '0);
    tick(1);
    chk("R3", "falling flag", flag, 4'(1 << p));
    chk("R3", "falling req", req, 4'(1 << p));
    pulse_clr(4'(1 << p));
    chk("R8", "cleared flag", flag, '0);
    pin[p] = 1'b1;
    tick(5);
    chk("R3", "rise ignored", flag, '0);
  endtask

  task automatic t_rise(input int p);
    do_reset({N{M_RISE}});
    pin[p] = 1'b0;
    tick(5);
    chk("R4", "fall ignored", flag, '0);
    pin[p] = 1'b1;
    tick(2);
    chk("R2", "rise before latency", flag, '0);
    tick(1);
    chk("R4", "rising flag", flag, 4'(1 << p));
  endtask

  task automatic t_any(input int p);
    do_reset({N{M_ANY}});
    pin[p] = 1'b0;
    tick(3);
    chk("R5", "any: fall", flag, 4'(1 << p));
    pulse_clr(4'(1 << p));
    pin[p] = 1'b1;
    tick(3);
    chk("R5", "any: rise", flag, 4'(1 << p));
  endtask

  task automatic t_level(input int p);
    do_reset({N{M_LOW}});
    pin[p] = 1'b0;
    tick(1);
    chk("R6", "req not yet", req, '0);
    tick(1);
    chk("R6", "req while low", req, 4'(1 << p));
    tick(6);
    chk("R6", "req held", req, 4'(1 << p));
    chk("R6", "flag quiet", flag, '0);
    pin[p] = 1'b1;
    tick(1);
    chk("R6", "req until sync", req, 4'(1 << p));
    tick(1);
    chk("R6", "req released", req, '0);
  endtask

  task automatic t_halt(input int p);
    do_reset({N{M_FALL}});
    run = 1'b0;
    pin[p] = 1'b0;
    tick(6);
    chk("R7", "halted no flag", flag, '0);
    run = 1'b1;
    tick(4);
    chk("R7", "no late edge", flag, '0);
    pin[p] = 1'b1;
    tick(3);
    pin[p] = 1'b0;
    tick(3);
    chk("R7", "edge after resume", flag, 4'(1 << p));
  endtask

  task automatic t_collide(input int p);
    do_reset({N{M_FALL}});
    pin[p] = 1'b0;
    tick(2);
    clr = 4'(1 << p);
    tick(1);
    clr = '0;
    chk("R9", "edge beats clear", flag, 4'(1 << p));
    pulse_clr(4'(1 << p));
    chk("R8", "later clear", flag, '0);
  endtask

  task automatic t_enable(input int p);
    do_reset({N{M_FALL}});
    en = '0;
    pin[p] = 1'b0;
    tick(3);
    chk("R10", "flag while disabled", flag, 4'(1 << p));
    chk("R10", "req while disabled", req, '0);
    en = '1;
    #1;
    chk("R10", "req on enable", req, 4'(1 << p));
  endtask

  task automatic t_mode_switch(input int p);
    do_reset({N{M_FALL}});
    pin[p] = 1'b0;
    tick(3);
    pin[p] = 1'b1;
    tick(3);
    chk("R11", "flag latched", flag, 4'(1 << p));
    mode[2*p +: 2] = M_LOW;
    tick(1);
    chk("R11", "flag cleared by level mode", flag, '0);
    chk("R11", "req with pin high", req, '0);
    mode[2*p +: 2] = M_FALL;
    tick(2);
    chk("R11", "flag stays clear", flag, '0);
  endtask

  task automatic t_mixed;
    do_reset({M_RISE, M_FALL, M_ANY, M_LOW});
    pin = '0;
    tick(3);
    chk("R12", "mixed flags", flag, 4'b0110);
    chk("R12", "mixed reqs", req, 4'b0111);
    pulse_clr(4'b0010);
    chk("R12", "clear one pin", flag, 4'b0100);
    pin = '1;
    tick(3);
    chk("R12", "mixed after rise", flag, 4'b1110);
    chk("R12", "level released", req, 4'b1110);
  endtask

  initial begin
    t_reset();
    for (int p = 0; p < N; p++) begin
      t_fall(p);
      t_rise(p);
      t_any(p);
      t_level(p);
    end
    t_halt(1);
    t_collide(2);
    t_enable(3);
    t_mode_switch(0);
    t_mixed();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule